// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Clock-Domain Bridge

This block carries one data word at a time from a sending clock domain to a receiving clock domain. The two clocks have no fixed relation. The sender accepts a word together with a one-cycle push pulse. It registers the word onto a bus that crosses between the domains, and then drives a level request. The receiver brings the request into its own clock domain through a flop chain. On the first cycle it sees the request high, it captures the bus and raises an acknowledge.

The acknowledge travels back through a second flop chain. When the sender sees it, the sender lowers the request. The receiver then lowers the acknowledge. The sender is idle again once it sees the synchronized acknowledge low. This return-to-zero exchange of four events makes up one transfer.

While a transfer is open, the sender reports busy. A push that arrives during that time is dropped, and the sender flags it with an overflow pulse. Each domain has its own clock and its own active-low reset.

Top module: `hs_cdc_bridge`

## Requirements
- R1: While either reset is held and in the first cycle after both are released with no push, `src_busy`, `src_ovf` and `dst_strobe` are 0 and `dst_word` is all zeros.
- R2: While the request toward the receiver is high, the word on the crossing bus does not change.
- R3: A transfer follows this order: the request rises, the acknowledge rises after the synchronized request is seen high, the request falls after the synchronized acknowledge is seen high, and the acknowledge falls after the synchronized request is seen low. The sender becomes idle only after the synchronized acknowledge is low.
- R4: Every accepted word appears once and only once on `dst_word`, with `dst_strobe` high for exactly one destination cycle. Words arrive in the order they were accepted.
- R5: A push sampled while `src_busy` is 1 is ignored: its word is never delivered. `src_ovf` is 1 for exactly the source cycle that follows such a push, and it is 0 in every other cycle.
- R6: A push sampled while `src_busy` is 0 is accepted, and `src_busy` is 1 in the next source cycle.
- R7: Each crossing signal passes through `SYNC_STAGES` (at least 2) flops clocked by the receiving domain. Transfers are correct when the destination clock is slower than the source clock, and when it is faster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| src_push | input | 1 | One-cycle pulse offering `src_word` |
| src_word | input | WIDTH | Word offered with the push |
| src_busy | output | 1 | A transfer is open; pushes are ignored |
| src_ovf | output | 1 | Pulse one cycle after an ignored push |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_word | output | WIDTH | Last word delivered |
| dst_strobe | output | 1 | One-cycle strobe marking a new `dst_word` |

## Verification
Some faults leave the sender's state machine stuck in a state other than idle. A stuck state holds `src_busy` high, so every later push raises `src_ovf` within one source cycle, and the run stalls until the watchdog ends it.

Other faults break the receiver's capture or edge detection. These show up as a strobe with no word outstanding, as two strobes in a row, or as a word that differs from the next one accepted. Each is visible on the destination cycle the strobe appears.

Faults in the overflow path are caught on the source cycle right after each push.

// File: rtl/hs_bridge_pkg.sv
package hs_bridge_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_REQ  = 2'd1,
        TX_DROP = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_WAIT = 1'b0,
        RX_ACK  = 1'b1
    } rx_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

    initial begin
        a_r7_min_stages: assert (STAGES >= 2);
    end
endmodule

// File: rtl/hs_tx.sv
module hs_tx
    import hs_bridge_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] word_in,
    input  logic             ack_async,
    output logic             req,
    output logic [WIDTH-1:0] bus_word,
    output logic             busy,
    output logic             ovf
);
    typedef struct packed {
        tx_state_e        state;
        logic [WIDTH-1:0] word;
        logic             req;
        logic             ovf;
    } tx_regs_t;

    tx_regs_t r_d, r_q;
    logic     ack_s;

    hs_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_async), .q(ack_s)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ovf = push && (r_q.state != TX_IDLE);
        case (r_q.state)
            TX_IDLE: if (push) begin
                r_d.word  = word_in;
                r_d.req   = 1'b1;
                r_d.state = TX_REQ;
            end
            TX_REQ: if (ack_s) begin
                r_d.req   = 1'b0;
                r_d.state = TX_DROP;
            end
            TX_DROP: if (!ack_s) begin
                r_d.state = TX_IDLE;
            end
            default: r_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: TX_IDLE, word: '0, req: 1'b0, ovf: 1'b0};
        else        r_q <= r_d;
    end

    assign req      = r_q.req;
    assign bus_word = r_q.word;
    assign busy     = (r_q.state != TX_IDLE);
    assign ovf      = r_q.ovf;

    // R2: bus word held while request stays high
    a_r2_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req && r_d.req) |=> $stable(r_q.word));
    // R3: request only falls after synchronized acknowledge seen high
    a_r3_req_falls_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req && !r_d.req) |-> ack_s);
    // R3: sender goes idle only with synchronized acknowledge low
    a_r3_idle_after_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_d.state == TX_IDLE) |-> !ack_s);
    // R5: push while busy flags overflow next cycle
    a_r5_ovf_on_busy_push: assert property (@(posedge clk) disable iff (!rst_n)
        (push && busy) |=> ovf);
    // R6: push while idle makes busy next cycle
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !busy) |=> (busy && req));
endmodule

// File: rtl/hs_rx.sv
module hs_rx
    import hs_bridge_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_async,
    input  logic [WIDTH-1:0] bus_word,
    output logic             ack,
    output logic [WIDTH-1:0] word_out,
    output logic             strobe
);
    typedef struct packed {
        rx_state_e        state;
        logic [WIDTH-1:0] word;
        logic             ack;
        logic             strobe;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic     req_s;

    hs_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(req_async), .q(req_s)
    );

    always_comb begin
        r_d        = r_q;
        r_d.strobe = 1'b0;
        case (r_q.state)
            RX_WAIT: if (req_s) begin
                r_d.word   = bus_word;
                r_d.strobe = 1'b1;
                r_d.ack    = 1'b1;
                r_d.state  = RX_ACK;
            end
            RX_ACK: if (!req_s) begin
                r_d.ack   = 1'b0;
                r_d.state = RX_WAIT;
            end
            default: r_d.state = RX_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: RX_WAIT, word: '0, ack: 1'b0, strobe: 1'b0};
        else        r_q <= r_d;
    end

    assign ack      = r_q.ack;
    assign word_out = r_q.word;
    assign strobe   = r_q.strobe;

    // R4: strobe never lasts two cycles
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    // R3: acknowledge rises only on a synchronized request
    a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.ack && r_d.ack) |-> req_s);
    // R3: acknowledge falls only once synchronized request is low
    a_r3_ack_falls_on_req_low: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ack && !r_d.ack) |-> !req_s);
endmodule

// File: rtl/hs_cdc_bridge.sv
module hs_cdc_bridge #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             src_push,
    input  logic [WIDTH-1:0] src_word,
    output logic             src_busy,
    output logic             src_ovf,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic [WIDTH-1:0] dst_word,
    output logic             dst_strobe
);
    logic             req_x, ack_x;
    logic [WIDTH-1:0] bus_x;

    hs_tx #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_tx (
        .clk(src_clk), .rst_n(src_rst_n), .push(src_push), .word_in(src_word),
        .ack_async(ack_x), .req(req_x), .bus_word(bus_x),
        .busy(src_busy), .ovf(src_ovf)
    );

    hs_rx #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_rx (
        .clk(dst_clk), .rst_n(dst_rst_n), .req_async(req_x), .bus_word(bus_x),
        .ack(ack_x), .word_out(dst_word), .strobe(dst_strobe)
    );
endmodule

// File: tb/sim_hs_cdc_bridge.sv
`timescale 1ns/1ps
module sim_hs_cdc_bridge;
    localparam int W = 8;

    logic         src_clk = 0, dst_clk = 0;
    logic         src_rst_n = 0, dst_rst_n = 0;
    logic         src_push = 0;
    logic [W-1:0] src_word = '0;
    logic         src_busy, src_ovf, dst_strobe;
    logic [W-1:0] dst_word;

    realtime dst_half = 6.1;
    int checks = 0, failures = 0;
    int delivered = 0, accepted = 0;
    logic [W-1:0] exp_q[$];
    logic exp_ovf = 0, exp_busy = 0, prev_strobe = 0, done = 0;

    hs_cdc_bridge #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_push(src_push),
        .src_word(src_word), .src_busy(src_busy), .src_ovf(src_ovf),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_word(dst_word),
        .dst_strobe(dst_strobe)
    );

    always #4 src_clk = ~src_clk;
    initial forever #(dst_half) dst_clk = ~dst_clk;

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // one source cycle: check last cycle's predictions, then drive
    task automatic src_cycle(input logic p, input logic [W-1:0] w);
        @(negedge src_clk);
        chk(src_ovf == exp_ovf, "R5 ovf", int'(src_ovf), int'(exp_ovf));
        if (exp_busy) chk(src_busy == 1'b1, "R6 busy after accept", int'(src_busy), 1);
        exp_ovf  = p && src_busy;
        exp_busy = p && !src_busy;
        if (p && !src_busy) begin
            exp_q.push_back(w);
            accepted++;
        end
        src_push = p;
        src_word = w;
    endtask

    // destination side reference comparison
    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (dst_strobe) begin
                chk(!prev_strobe, "R4 strobe one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 duplicate word", int'(dst_word), -1);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(dst_word == e, "R4 word order", int'(dst_word), int'(e));
                    delivered++;
                end
            end
            prev_strobe = dst_strobe;
        end
    end

    initial begin
        int wd = 0;
        while (wd < 150000) begin
            @(negedge src_clk);
            wd++;
        end
        chk(1'b0, "watchdog", wd, 0);
        finish_run();
    end

    task automatic run_phase(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            while (src_busy) src_cycle(1'b0, '0);
            src_cycle(1'b1, W'(i * 37 + seed));
            if (i % 3 == 0) src_cycle(1'b1, W'(i * 37 + seed) ^ 8'hA5); // R5 ignored
            else            src_cycle(1'b0, '0);
        end
        src_cycle(1'b0, '0);
        while (src_busy || exp_q.size() != 0) src_cycle(1'b0, '0);
        repeat (6) src_cycle(1'b0, '0);
        chk(delivered == accepted, "R7 count after phase", delivered, accepted);
        chk(exp_q.size() == 0, "R4 no loss", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge src_clk);
        // R1: under reset
        chk(!src_busy && !src_ovf, "R1 src in reset", int'(src_busy), 0);
        chk(!dst_strobe && dst_word == '0, "R1 dst in reset", int'(dst_word), 0);
        src_rst_n = 1;
        dst_rst_n = 1;
        @(negedge src_clk);
        chk(!src_busy && !src_ovf, "R1 src after reset", int'(src_busy), 0);
        chk(!dst_strobe && dst_word == '0, "R1 dst after reset", int'(dst_word), 0);
        // R7: destination slower than source
        run_phase(20, 3);
        // R3: sender idle after full handshake
        chk(!src_busy, "R3 idle after handshake", int'(src_busy), 0);
        // R7: destination faster than source
        dst_half = 2.3;
        run_phase(20, 11);
        chk(!src_busy, "R3 idle after handshake fast", int'(src_busy), 0);
        chk(accepted == 40, "R6 accepted count", accepted, 40);
        finish_run();
    end
endmodule